// File: doc/BRIEF.md
# Comparator Output Control

This block is the digital wrapper around one analog comparator channel. It holds a small control byte with three control bits and three spare bits. It takes the comparator's decision, already synchronized to the local clock, and produces the value for the output pin and the enable for the pin driver. Software-visible state is limited to the control byte, which is written through a strobe and data bus and read back continuously.

The three control bits act independently. The power bit marks the comparator as powered. The enable bit turns on the output driver. The latch bit freezes the output at the decision seen when the bit rises. A settle counter holds the driver off for a programmable number of cycles after power and enable both become set, which covers the analog start-up time.

Both outputs are registered. Whenever the channel is unpowered, disabled or still settling, both outputs are forced low.

Top module: `cmpctl_top`

## Requirements
- R1: After reset the control byte reads 0x00 and both `out_val_o` and `out_en_o` are low.
- R2: The control byte layout is bit 0 power (1 = powered), bit 1 output enable, bit 2 latch, bits 5:3 user bits, and bits 7:6 always read 0. A write appears on `ctl_rdata_o` from the cycle after the strobe.
- R3: While the power bit is 0, `out_en_o` and `out_val_o` are both 0 from the following cycle onwards.
- R4: While the enable bit is 0, `out_en_o` and `out_val_o` are both 0 from the following cycle onwards, even when the channel is powered.
- R5: The power and enable bits can become both 1 through a write that is sampled at clock edge k. In that case `out_en_o` is still 0 after edge k+SETTLE_CYCLES and is 1 after edge k+SETTLE_CYCLES+1.
- R6: Rewriting the control byte while power and enable stay 1 does not restart the settle delay, so `out_en_o` stays high.
- R7: With the latch bit 0 and the output valid, `out_val_o` equals `cmp_raw_i` as sampled at the previous clock edge.
- R8: When the latch bit rises, the decision present in the first cycle after the write is captured. `out_val_o` then keeps that value while the latch bit stays 1, whatever `cmp_raw_i` does.
- R9: The user bits are stored and read back, and they change neither `out_val_o` nor `out_en_o`.
- R10: Clearing the latch bit makes `out_val_o` follow `cmp_raw_i` again from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_we_i | input | 1 | Control byte write strobe |
| ctl_wdata_i | input | 8 | Control byte write data |
| ctl_rdata_o | output | 8 | Control byte read back |
| cmp_raw_i | input | 1 | Synchronized comparator decision (1 = input above wiper) |
| out_val_o | output | 1 | Value for the output pin |
| out_en_o | output | 1 | Output driver enable |

## Verification
The bench builds the block with SETTLE_CYCLES set to 5 rather than the default 200. This keeps both settle boundaries, the last cycle low and the first cycle high, within a few cycles of each write. That makes it practical to hit the settle edge exactly after a power-up and again after a later rise of the enable bit. The same short delay also leaves room to freeze the output with the latch, toggle the comparator input and check each forced-low state in a short run.

// File: rtl/cmpctl_pkg.sv
package cmpctl_pkg;
  localparam int unsigned CTL_W = 8;
  localparam int unsigned USR_W = 3;
  localparam int unsigned RSV_W = CTL_W - USR_W - 3;

  typedef struct packed {
    logic [RSV_W-1:0] rsvd;
    logic [USR_W-1:0] usr;
    logic             latch;
    logic             enable;
    logic             power;
  } ctl_reg_t;

  function automatic ctl_reg_t ctl_clean(input logic [CTL_W-1:0] raw);
    ctl_reg_t r;
    r      = ctl_reg_t'(raw);
    r.rsvd = '0;
    return r;
  endfunction
endpackage

// File: rtl/cmpctl_regs.sv
module cmpctl_regs
  import cmpctl_pkg::*;
#(
  parameter logic [CTL_W-1:0] RESET_CTL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  output logic [CTL_W-1:0] rdata_o,
  output logic             power_o,
  output logic             enable_o,
  output logic             latch_o
);
  localparam ctl_reg_t RST_VAL = ctl_clean(RESET_CTL);

  ctl_reg_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_q <= RST_VAL;
    else if (we_i) ctl_q <= ctl_clean(wdata_i);
  end

  assign rdata_o  = ctl_q;
  assign power_o  = ctl_q.power;
  assign enable_o = ctl_q.enable;
  assign latch_o  = ctl_q.latch;
endmodule

// File: rtl/cmpctl_settle.sv
module cmpctl_settle #(
  parameter int unsigned SETTLE_CYCLES = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  output logic done_o
);
  generate
    if (SETTLE_CYCLES == 0) begin : g_bypass
      assign done_o = active_i;
    end else begin : g_count
      localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1);
      localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYCLES);
      logic [CW-1:0] cnt_q;

      // reload whenever inactive, so every activation restarts the delay
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             cnt_q <= LOAD;
        else if (!active_i)      cnt_q <= LOAD;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
      end

      assign done_o = active_i && (cnt_q == '0);
    end
  endgenerate
endmodule

// File: rtl/cmpctl_hold.sv
module cmpctl_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic latch_i,
  input  logic cmp_i,
  output logic sel_o
);
  logic latch_d_q;
  logic hold_q;
  logic latch_rise;

  assign latch_rise = latch_i && !latch_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_d_q <= 1'b0;
      hold_q    <= 1'b0;
    end else begin
      latch_d_q <= latch_i;
      if (latch_rise) hold_q <= cmp_i;
    end
  end

  // in the rise cycle the live value is the one being captured
  assign sel_o = (latch_i && !latch_rise) ? hold_q : cmp_i;
endmodule

// File: rtl/cmpctl_top.sv
module cmpctl_top
  import cmpctl_pkg::*;
#(
  parameter int unsigned      SETTLE_CYCLES = 200,
  parameter logic [CTL_W-1:0] RESET_CTL     = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  output logic [CTL_W-1:0] ctl_rdata_o,
  input  logic             cmp_raw_i,
  output logic             out_val_o,
  output logic             out_en_o
);
  logic power, enable, latch;
  logic active, settled, sel;
  logic val_q, en_q;

  cmpctl_regs #(.RESET_CTL(RESET_CTL)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ctl_we_i),
    .wdata_i  (ctl_wdata_i),
    .rdata_o  (ctl_rdata_o),
    .power_o  (power),
    .enable_o (enable),
    .latch_o  (latch)
  );

  assign active = power && enable;

  cmpctl_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .done_o   (settled)
  );

  cmpctl_hold u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .latch_i (latch),
    .cmp_i   (cmp_raw_i),
    .sel_o   (sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      en_q  <= settled;
      val_q <= settled && sel;
    end
  end

  assign out_val_o = val_q;
  assign out_en_o  = en_q;
endmodule

// File: rtl/cmpctl_chk.sv
module cmpctl_chk #(
  parameter int unsigned SETTLE_CYCLES = 200
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ctl_we_i,
  input logic [5:0] ctl_wdata_i,
  input logic [7:0] ctl_rdata_o,
  input logic       out_val_o,
  input logic       out_en_o
);
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |=> (ctl_rdata_o == 8'h00) || !rst_ni); // R1

  AST_WRITE_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> ctl_rdata_o == {2'b00, $past(ctl_wdata_i)}); // R2

  AST_UNPOWERED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_rdata_o[0] |=> !out_en_o && !out_val_o); // R3

  AST_DISABLED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_rdata_o[1] |=> !out_en_o && !out_val_o); // R4

  AST_SETTLE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SETTLE_CYCLES > 0) && ctl_we_i && (ctl_wdata_i[1:0] == 2'b11) &&
    (ctl_rdata_o[1:0] != 2'b11) |=> ##1 !out_en_o); // R5

  AST_LATCH_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctl_rdata_o[2]) && $past(ctl_rdata_o[2], 2) && out_en_o && $past(out_en_o)
    |-> $stable(out_val_o)); // R8
endmodule

bind cmpctl_top cmpctl_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctl_we_i    (ctl_we_i),
  .ctl_wdata_i (ctl_wdata_i[5:0]),
  .ctl_rdata_o (ctl_rdata_o),
  .out_val_o   (out_val_o),
  .out_en_o    (out_en_o)
);

// File: tb/cmpctl_top_tb.sv
`timescale 1ns/1ps
module cmpctl_top_tb;
  localparam int unsigned S = 5;

  typedef struct {
    int unsigned stamp;
    logic        v;
    logic        e;
    logic [7:0]  rd;
    string       req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       raw = 1'b0;
  logic       val, en;

  int unsigned cyc = 0;
  int unsigned base = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cmpctl_top #(.SETTLE_CYCLES(S)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ctl_we_i    (we),
    .ctl_wdata_i (wdata),
    .ctl_rdata_o (rdata),
    .cmp_raw_i   (raw),
    .out_val_o   (val),
    .out_en_o    (en)
  );

  task automatic push(input int unsigned st, input logic v, input logic e,
                      input logic [7:0] rd, input string req);
    exp_t x;
    x.stamp = st; x.v = v; x.e = e; x.rd = rd; x.req = req;
    q.push_back(x);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; wdata = d; base = cyc;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic set_raw(input logic b);
    @(negedge clk);
    raw = b; base = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares scoreboard head against outputs away from the edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].stamp <= cyc) begin
      exp_t x;
      x = q.pop_front();
      checks++;
      if (x.stamp != cyc || val !== x.v || en !== x.e || rdata !== x.rd) begin
        fails++;
        $display("FAIL %s @%0d: val=%0b en=%0b rd=%h expected val=%0b en=%0b rd=%h",
                 x.req, cyc, val, en, rdata, x.v, x.e, x.rd);
      end
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    base = cyc;
    push(base + 1, 0, 0, 8'h00, "R1");
    idle(3);

    // power+enable with decision high: settle boundary
    set_raw(1);
    wr(8'h03);
    push(base + 2,     0, 0, 8'h03, "R2");
    push(base + S + 1, 0, 0, 8'h03, "R5");
    push(base + S + 2, 1, 1, 8'h03, "R5");
    idle(S + 3);

    // live following
    set_raw(0);
    push(base + 2, 0, 1, 8'h03, "R7");
    idle(3);
    set_raw(1);
    push(base + 2, 1, 1, 8'h03, "R7");
    idle(3);

    // latch freezes the high value
    wr(8'h07);
    push(base + 3, 1, 1, 8'h07, "R8");
    idle(3);
    set_raw(0);
    push(base + 2, 1, 1, 8'h07, "R8");
    push(base + 4, 1, 1, 8'h07, "R8");
    idle(5);

    // latch cleared: follows low decision
    wr(8'h03);
    push(base + 2, 0, 1, 8'h03, "R10");
    idle(3);

    // rewrite while active: no settle restart
    set_raw(1);
    idle(3);
    wr(8'h03);
    push(base + 2, 1, 1, 8'h03, "R6");
    push(base + 4, 1, 1, 8'h03, "R6");
    idle(5);

    // user bits stored, upper bits read 0, no behavioural effect
    wr(8'hFB);
    push(base + 2, 1, 1, 8'h3B, "R9");
    idle(3);
    set_raw(0);
    push(base + 2, 0, 1, 8'h3B, "R9");
    idle(3);

    // power off
    wr(8'h3A);
    push(base + 2, 0, 0, 8'h3A, "R3");
    idle(3);
    set_raw(1);
    push(base + 2, 0, 0, 8'h3A, "R3");
    idle(3);

    // powered but disabled
    wr(8'h01);
    push(base + 2,     0, 0, 8'h01, "R4");
    push(base + S + 3, 0, 0, 8'h01, "R4");
    idle(S + 4);

    // enable rise restarts settle
    wr(8'h03);
    push(base + S + 1, 0, 0, 8'h03, "R5");
    push(base + S + 2, 1, 1, 8'h03, "R5");
    idle(S + 4);

    if (q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: %0d pending, expected 0", q.size());
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule